// File: doc/BRIEF.md
# Interrupt Delegation and Routing Unit

This block keeps the machine-level interrupt pending, enable and delegation state of one hart and decides, every cycle, whether an interrupt trap must be raised. It also decides which privilege level the trap goes to. The supervisor pending and enable registers have no storage of their own. Each is the matching machine register seen through the delegation mask. A supervisor write changes the same bit position in the machine register, and only where that bit is delegated and writable.

The three machine-level sources are level wires from outside the block: software, timer and external. Their pending bits follow those wires and cannot be written through the CSR port. The supervisor software, timer and external pending bits are held in flops and are set and cleared by software. Delegation of the three supervisor interrupts is always possible. Delegation of each machine interrupt is chosen at build time: its delegation bit is either a writable flop or a constant zero.

The trap decision is combinational from the register state, the source wires, the current privilege level and the two global enable bits. The trap target is reported as a privilege code and the cause is reported as the index of the winning bit.

Top module: `irq_route_unit`

## Requirements
- R1: After a synchronous active-low reset, the delegation register, the enable register and the software-writable pending bits are all zero, and no trap is requested while the source wires are low.
- R2: Reading the supervisor pending view (address 0x144) returns the machine pending value AND the delegation register. Reading the supervisor enable view (address 0x104) returns the machine enable value AND the delegation register.
- R3: Writes to the supervisor views update the same bit positions in the machine registers. Only bits that are delegated are changed: bits 1, 5 and 9 for pending, and any implemented bit for enable. All other bits keep their value. A machine enable write (address 0x304) stores only the implemented bits 1, 3, 5, 7, 9 and 11.
- R4: Machine pending (address 0x344) bits 3, 7 and 11 follow the software, timer and external wires. Writes to those bits are ignored. Bits 1, 5 and 9 are written directly.
- R5: The delegation register (address 0x303) accepts bits 1, 5 and 9, plus each of bits 3, 7 and 11 only when its build parameter allows it. All other bits, and reads of any other address, return zero.
- R6: An interrupt whose delegation bit is set is never taken while the current privilege is machine (code 3).
- R7: A delegated interrupt traps to supervisor (target code 1) only when its pending and enable bits are both set and the privilege is user (code 0), or is supervisor (code 1) with the supervisor global enable set.
- R8: An undelegated interrupt traps to machine (target code 3) only when its pending and enable bits are both set and the privilege is below machine or the machine global enable is set.
- R9: Among the eligible interrupts, the winner is chosen in the order bit 11, 3, 7, 9, 1, 5. The cause output is the winner's bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| irq_msw_i | input | 1 | Machine software interrupt wire |
| irq_mtimer_i | input | 1 | Machine timer interrupt wire |
| irq_mext_i | input | 1 | Machine external interrupt wire |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mie_glb_i | input | 1 | Machine global interrupt enable |
| sie_glb_i | input | 1 | Supervisor global interrupt enable |
| trap_req_o | output | 1 | Interrupt trap request |
| trap_lvl_o | output | 2 | Target privilege of the trap |
| trap_cause_o | output | $clog2(XLEN) | Cause code (winning bit index) |

## Verification
Two things can happen in the same cycle: a CSR write that changes delegation or enable, and a trap decision that depends on the old values of those registers. The bench provokes this with random writes to all five addresses, while it randomly toggles the source wires, the privilege and the global enables. A behavioural model holds the register state and updates it only at the clock edge. Each cycle it predicts the read data, the trap request, the target and the cause from the pre-edge state. Any mismatch in that cycle, or in the next cycle's readback, exposes a write that took effect too early or too late, or that landed in the wrong bit.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the interrupt routing unit.
// Assumes a register width of at least 12 bits.
package irq_route_pkg;
    // interrupt bit positions (shared by every register view)
    localparam int unsigned BIT_SSW = 1;
    localparam int unsigned BIT_MSW = 3;
    localparam int unsigned BIT_STM = 5;
    localparam int unsigned BIT_MTM = 7;
    localparam int unsigned BIT_SEX = 9;
    localparam int unsigned BIT_MEX = 11;

    localparam int unsigned NUM_SRC = 6;
    // arbitration order, highest first
    localparam int unsigned PRIO_ORDER [0:NUM_SRC-1] =
        '{BIT_MEX, BIT_MSW, BIT_MTM, BIT_SEX, BIT_SSW, BIT_STM};

    // privilege codes
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // CSR addresses
    localparam logic [11:0] CSR_SEN    = 12'h104;
    localparam logic [11:0] CSR_SPEND  = 12'h144;
    localparam logic [11:0] CSR_MDELEG = 12'h303;
    localparam logic [11:0] CSR_MEN    = 12'h304;
    localparam logic [11:0] CSR_MPEND  = 12'h344;
endpackage

// File: rtl/irq_csr_bank.sv
`timescale 1ns/1ps
// Module: irq_csr_bank
// Holds the machine pending, enable and delegation state and decodes the CSR
// port. The supervisor views are masks of the machine registers.
// Assumes XLEN >= 12; reads are combinational, writes land at the clock edge.
module irq_csr_bank
    import irq_route_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter bit          DELEG_MSW = 1'b0,
    parameter bit          DELEG_MTM = 1'b1,
    parameter bit          DELEG_MEX = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            irq_msw_i,
    input  logic            irq_mtimer_i,
    input  logic            irq_mext_i,
    output logic [XLEN-1:0] pend_o,
    output logic [XLEN-1:0] en_o,
    output logic [XLEN-1:0] deleg_o
);
    localparam logic [XLEN-1:0] SW_PEND_MASK =
        XLEN'((32'd1 << BIT_SSW) | (32'd1 << BIT_STM) | (32'd1 << BIT_SEX));
    localparam logic [XLEN-1:0] HW_PEND_MASK =
        XLEN'((32'd1 << BIT_MSW) | (32'd1 << BIT_MTM) | (32'd1 << BIT_MEX));
    localparam logic [XLEN-1:0] IMPL_MASK = SW_PEND_MASK | HW_PEND_MASK;
    localparam logic [XLEN-1:0] DELEG_WMASK = SW_PEND_MASK
        | (XLEN'(DELEG_MSW) << BIT_MSW)
        | (XLEN'(DELEG_MTM) << BIT_MTM)
        | (XLEN'(DELEG_MEX) << BIT_MEX);

    logic [XLEN-1:0] pend_sw_q;
    logic [XLEN-1:0] en_q;
    logic [XLEN-1:0] deleg_q;
    logic [XLEN-1:0] pend_hw;
    logic [XLEN-1:0] s_pend_wmask;
    logic [XLEN-1:0] s_en_wmask;
    logic            wr_mpend, wr_spend, wr_men, wr_sen, wr_deleg;

    // write strobe decode
    always_comb begin
        wr_mpend = csr_we && (csr_addr == CSR_MPEND);
        wr_spend = csr_we && (csr_addr == CSR_SPEND);
        wr_men   = csr_we && (csr_addr == CSR_MEN);
        wr_sen   = csr_we && (csr_addr == CSR_SEN);
        wr_deleg = csr_we && (csr_addr == CSR_MDELEG);
    end

    // wire-driven machine pending bits
    always_comb begin
        pend_hw          = '0;
        pend_hw[BIT_MSW] = irq_msw_i;
        pend_hw[BIT_MTM] = irq_mtimer_i;
        pend_hw[BIT_MEX] = irq_mext_i;
    end

    // supervisor writes reach only delegated, writable bits
    always_comb begin
        s_pend_wmask = SW_PEND_MASK & deleg_q;
        s_en_wmask   = IMPL_MASK & deleg_q;
    end

    // software-writable pending flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sw_q <= '0;
        end else if (wr_mpend) begin
            pend_sw_q <= csr_wdata & SW_PEND_MASK;
        end else if (wr_spend) begin
            pend_sw_q <= (pend_sw_q & ~s_pend_wmask) | (csr_wdata & s_pend_wmask);
        end
    end

    // enable flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_men) begin
            en_q <= csr_wdata & IMPL_MASK;
        end else if (wr_sen) begin
            en_q <= (en_q & ~s_en_wmask) | (csr_wdata & s_en_wmask);
        end
    end

    // delegation bits: a flop where the build allows it, a constant zero elsewhere
    for (genvar i = 0; i < int'(XLEN); i++) begin : g_deleg
        if (DELEG_WMASK[i]) begin : g_rw
            logic bit_q;
            // one writable delegation bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (wr_deleg) begin
                    bit_q <= csr_wdata[i];
                end
            end
            assign deleg_q[i] = bit_q;
        end else begin : g_ro
            assign deleg_q[i] = 1'b0;
        end
    end

    assign pend_o  = pend_sw_q | pend_hw;
    assign en_o    = en_q;
    assign deleg_o = deleg_q;

    // read mux with supervisor masking
    always_comb begin
        case (csr_addr)
            CSR_MPEND:  csr_rdata = pend_sw_q | pend_hw;
            CSR_SPEND:  csr_rdata = (pend_sw_q | pend_hw) & deleg_q;
            CSR_MEN:    csr_rdata = en_q;
            CSR_SEN:    csr_rdata = en_q & deleg_q;
            CSR_MDELEG: csr_rdata = deleg_q;
            default:    csr_rdata = '0;
        endcase
    end

    // R3
    spend_keeps_undelegated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_spend |=> ((pend_sw_q & ~$past(deleg_q)) == ($past(pend_sw_q) & ~$past(deleg_q))));
    // R3
    sen_keeps_undelegated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sen |=> ((en_q & ~$past(deleg_q)) == ($past(en_q) & ~$past(deleg_q))));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
// Module: irq_arbiter
// Finds the interrupts that may be taken now and picks one by fixed priority.
// Assumes the privilege code 2 is treated like a level below machine.
module irq_arbiter
    import irq_route_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]    pend_i,
    input  logic [XLEN-1:0]    en_i,
    input  logic [XLEN-1:0]    deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               mie_glb_i,
    input  logic               sie_glb_i,
    output logic               trap_req_o,
    output logic [1:0]         trap_lvl_o,
    output logic [CAUSE_W-1:0] trap_cause_o
);
    logic            s_open, m_open;
    logic [XLEN-1:0] ready;
    logic [XLEN-1:0] elig;

    // level gates for each target
    always_comb begin
        s_open = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_glb_i);
        m_open = (priv_i != PRIV_M) || mie_glb_i;
    end

    // per-bit eligibility: delegated bits use the supervisor gate
    always_comb begin
        ready = pend_i & en_i;
        for (int b = 0; b < int'(XLEN); b++) begin
            elig[b] = ready[b] && (deleg_i[b] ? s_open : m_open);
        end
    end

    // fixed-priority pick; the earliest list entry is written last and wins
    always_comb begin
        trap_req_o   = 1'b0;
        trap_cause_o = '0;
        trap_lvl_o   = PRIV_M;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (elig[PRIO_ORDER[k]]) begin
                trap_req_o   = 1'b1;
                trap_cause_o = CAUSE_W'(PRIO_ORDER[k]);
                trap_lvl_o   = deleg_i[PRIO_ORDER[k]] ? PRIV_S : PRIV_M;
            end
        end
    end
endmodule

// File: rtl/irq_route_unit.sv
`timescale 1ns/1ps
// Module: irq_route_unit (top)
// Interrupt pending/enable/delegation state with supervisor views and trap routing.
// Assumes inputs are synchronous to clk; trap outputs are combinational.
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter bit          DELEG_MSW = 1'b0,
    parameter bit          DELEG_MTM = 1'b1,
    parameter bit          DELEG_MEX = 1'b0,
    localparam int unsigned CAUSE_W  = $clog2(XLEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        csr_addr,
    input  logic               csr_we,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic               irq_msw_i,
    input  logic               irq_mtimer_i,
    input  logic               irq_mext_i,
    input  logic [1:0]         priv_i,
    input  logic               mie_glb_i,
    input  logic               sie_glb_i,
    output logic               trap_req_o,
    output logic [1:0]         trap_lvl_o,
    output logic [CAUSE_W-1:0] trap_cause_o
);
    logic [XLEN-1:0] pend_w, en_w, deleg_w;

    irq_csr_bank #(
        .XLEN(XLEN), .DELEG_MSW(DELEG_MSW), .DELEG_MTM(DELEG_MTM), .DELEG_MEX(DELEG_MEX)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .irq_msw_i(irq_msw_i), .irq_mtimer_i(irq_mtimer_i), .irq_mext_i(irq_mext_i),
        .pend_o(pend_w), .en_o(en_w), .deleg_o(deleg_w)
    );

    irq_arbiter #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_arb (
        .pend_i(pend_w), .en_i(en_w), .deleg_i(deleg_w),
        .priv_i(priv_i), .mie_glb_i(mie_glb_i), .sie_glb_i(sie_glb_i),
        .trap_req_o(trap_req_o), .trap_lvl_o(trap_lvl_o), .trap_cause_o(trap_cause_o)
    );

    // R6
    deleg_quiet_in_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_o && (priv_i == PRIV_M)) |-> (trap_lvl_o == PRIV_M));
    // R7
    sup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_o && (trap_lvl_o == PRIV_S)) |->
            ((priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_glb_i)));
    // R8
    mach_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_o && (trap_lvl_o == PRIV_M)) |-> ((priv_i != PRIV_M) || mie_glb_i));
    // R9
    cause_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (pend_w[trap_cause_o] && en_w[trap_cause_o]));
endmodule

// File: tb/irq_route_unit_bench.sv
`timescale 1ns/1ps
module irq_route_unit_bench;
    localparam logic [11:0] A_SEN = 12'h104, A_SPEND = 12'h144, A_MDELEG = 12'h303,
                            A_MEN = 12'h304, A_MPEND = 12'h344, A_NONE = 12'h345;
    localparam logic [31:0] SWM = 32'h222, IMPL = 32'hAAA, DLW = 32'h2A2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic we = 1'b0;
    logic [31:0] wd = '0;
    logic msw = 1'b0, mt = 1'b0, me = 1'b0;
    logic [1:0] pv = 2'd3;
    logic mg = 1'b0, sg = 1'b0;
    logic [31:0] rdata;
    logic req;
    logic [1:0] lvl;
    logic [4:0] cause;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] m_sw = '0, m_en = '0, m_dl = '0;
    bit m_valid = 1'b0;

    always #10 clk = ~clk;

    irq_route_unit #(.XLEN(32), .DELEG_MSW(1'b0), .DELEG_MTM(1'b1), .DELEG_MEX(1'b0)) u_irq_route_unit (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd), .csr_rdata(rdata),
        .irq_msw_i(msw), .irq_mtimer_i(mt), .irq_mext_i(me), .priv_i(pv),
        .mie_glb_i(mg), .sie_glb_i(sg), .trap_req_o(req), .trap_lvl_o(lvl), .trap_cause_o(cause)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // one cycle: drive, compare against the model, advance the model at the edge
    // lk: 0 none, 1 read data, 2 request, 3 cause, 4 target level
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input int lk, input logic [31:0] lx, input string lt);
        logic [31:0] pend, erd;
        int order [6] = '{11, 3, 7, 9, 1, 5};
        bit ereq;
        logic [1:0] elvl;
        int ecause;
        string rtag, qtag;
        addr = a; we = w; wd = d;
        #1;
        pend = m_sw | (32'(msw) << 3) | (32'(mt) << 7) | (32'(me) << 11);
        case (a)
            A_MPEND:  begin erd = pend;          rtag = "R4"; end
            A_SPEND:  begin erd = pend & m_dl;   rtag = "R2"; end
            A_MEN:    begin erd = m_en;          rtag = "R3"; end
            A_SEN:    begin erd = m_en & m_dl;   rtag = "R2"; end
            A_MDELEG: begin erd = m_dl;          rtag = "R5"; end
            default:  begin erd = '0;            rtag = "R5"; end
        endcase
        ereq = 1'b0; elvl = 2'd3; ecause = 0;
        for (int k = 0; k < 6; k++) begin
            int b = order[k];
            bit ok;
            if (m_dl[b]) ok = (pv == 2'd0) || (pv == 2'd1 && sg);
            else         ok = (pv != 2'd3) || mg;
            if (!ereq && pend[b] && m_en[b] && ok) begin
                ereq = 1'b1; ecause = b; elvl = m_dl[b] ? 2'd1 : 2'd3;
            end
        end
        if (!rst_n) begin rtag = "R1"; qtag = "R1"; end
        else if (ereq && elvl == 2'd1) qtag = "R7";
        else if (pv == 2'd3) qtag = "R6";
        else qtag = "R8";
        if (m_valid) begin
            chk(rtag, rdata, erd);
            chk(qtag, 32'(req), 32'(ereq));
            if (ereq) begin
                chk("R9", 32'(cause), 32'(ecause));
                chk("R7", 32'(lvl), 32'(elvl));
            end
        end
        case (lk)
            1: chk(lt, rdata, lx);
            2: chk(lt, 32'(req), lx);
            3: chk(lt, 32'(cause), lx);
            4: chk(lt, 32'(lvl), lx);
            default: ;
        endcase
        @(posedge clk);
        if (!rst_n) begin
            m_sw = '0; m_en = '0; m_dl = '0; m_valid = 1'b1;
        end else if (w) begin
            case (a)
                A_MPEND:  m_sw = d & SWM;
                A_SPEND:  m_sw = (m_sw & ~(SWM & m_dl)) | (d & SWM & m_dl);
                A_MEN:    m_en = d & IMPL;
                A_SEN:    m_en = (m_en & ~(IMPL & m_dl)) | (d & IMPL & m_dl);
                A_MDELEG: m_dl = d & DLW;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] alist [6] = '{A_SEN, A_SPEND, A_MDELEG, A_MEN, A_MPEND, A_NONE};
        logic [1:0]  plist [3] = '{2'd0, 2'd1, 2'd3};
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(A_MPEND, 1'b0, '0, 0, '0, "");
        rst_n = 1'b1;
        // reset state, R1
        cyc(A_MPEND, 0, 0, 1, 0, "R1");
        cyc(A_MDELEG, 0, 0, 1, 0, "R1");
        cyc(A_MEN, 0, 0, 1, 0, "R1");
        cyc(A_MEN, 0, 0, 2, 0, "R1");
        // delegation write mask, R5
        cyc(A_MDELEG, 1, 32'hFFFF_FFFF, 0, 0, "");
        cyc(A_MDELEG, 0, 0, 1, 32'h2A2, "R5");
        cyc(A_MDELEG, 1, 32'h808, 0, 0, "");
        cyc(A_MDELEG, 0, 0, 1, 32'h0, "R5");
        cyc(A_NONE, 0, 0, 1, 32'h0, "R5");
        // machine pending write ignores wire bits, R4
        cyc(A_MPEND, 1, 32'hFFFF_FFFF, 0, 0, "");
        cyc(A_MPEND, 0, 0, 1, 32'h222, "R4");
        // supervisor view masking and aliasing, R2 R3
        cyc(A_MDELEG, 1, 32'h20, 0, 0, "");
        cyc(A_SPEND, 0, 0, 1, 32'h20, "R2");
        cyc(A_SPEND, 1, 32'h0, 0, 0, "");
        cyc(A_MPEND, 0, 0, 1, 32'h202, "R3");
        mt = 1'b1;
        cyc(A_MPEND, 0, 0, 1, 32'h282, "R4");
        cyc(A_SPEND, 0, 0, 1, 32'h0, "R2");
        cyc(A_MEN, 1, 32'hFFFF_FFFF, 0, 0, "");
        cyc(A_MEN, 0, 0, 1, 32'hAAA, "R3");
        cyc(A_SEN, 0, 0, 1, 32'h20, "R2");
        cyc(A_SEN, 1, 32'h0, 0, 0, "");
        cyc(A_MEN, 0, 0, 1, 32'hA8A, "R3");
        cyc(A_MEN, 1, 32'hFFFF_FFFF, 0, 0, "");
        // machine gating and priority, R8 R9
        cyc(A_NONE, 0, 0, 2, 0, "R8");
        mg = 1'b1;
        cyc(A_NONE, 0, 0, 2, 1, "R8");
        cyc(A_NONE, 0, 0, 3, 7, "R9");
        // delegated timer hidden in machine mode, R6
        cyc(A_MDELEG, 1, 32'h80, 0, 0, "");
        cyc(A_NONE, 0, 0, 3, 9, "R6");
        cyc(A_MDELEG, 1, 32'h282, 0, 0, "");
        cyc(A_NONE, 0, 0, 2, 0, "R6");
        // supervisor gating, R7
        pv = 2'd1; sg = 1'b0;
        cyc(A_NONE, 0, 0, 2, 0, "R7");
        sg = 1'b1;
        cyc(A_NONE, 0, 0, 3, 7, "R7");
        cyc(A_NONE, 0, 0, 4, 1, "R7");
        pv = 2'd0; sg = 1'b0;
        cyc(A_NONE, 0, 0, 3, 7, "R7");
        // top priority source, R9
        pv = 2'd3; msw = 1'b1; me = 1'b1;
        cyc(A_MPEND, 1, 32'h0, 3, 11, "R9");
        cyc(A_MPEND, 0, 0, 1, 32'h888, "R4");
        me = 1'b0;
        cyc(A_NONE, 0, 0, 3, 3, "R9");
        // random phase: model compared every cycle
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] r = $urandom;
            rst_n = ($urandom_range(0, 299) != 0);
            msw = r[0]; mt = r[1]; me = r[2] & r[3];
            pv = plist[$urandom_range(0, 2)];
            mg = r[4]; sg = r[5];
            cyc(alist[$urandom_range(0, 5)], ($urandom_range(0, 2) == 0), $urandom, 0, 0, "");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule